// File: doc/BRIEF.md
# SD Host Interrupt Status Block

This block keeps the two interrupt/status words of an SD card host controller and the mask word that goes with each one. The command engine, the data engine and the card socket report to it through single-cycle event pulses and through plain level inputs. Pulses are stored in sticky flags. Levels are shown live in the same words.

Software reaches the block through a 32-bit register port. A read returns data one cycle after the request. A write to a status word clears every flag whose data bit is 0. A write to a mask word replaces the whole mask. One interrupt line is driven high while any sticky flag in either word is set and not masked.

The buffer-ready flags are set once per rising edge of the buffer level, not held by it. Software can therefore clear such a flag before it drains the buffer, and the next buffer event still sets it again. The card-detect pin is asynchronous. It passes through a synchronizer, and the synchronized value is both shown live and used to detect insertion and removal.

Top module: `sdh_irq_status`

## Requirements
- R1: After reset every sticky flag is 0, both mask words read 0xFFFFFFFF and `irq` is low. A status word then reads back only its live-level bits.
- R2: An event pulse sets its flag at the next clock edge. In word 1 (offset 0x038), `ev_rsp_done` sets bit 0 and `ev_xfer_done` sets bit 2. In word 2 (offset 0x03C), `ev_err[0]` through `ev_err[6]` set bits 0 through 6 (command index, CRC, end bit, data timeout, illegal write, illegal read, response timeout), and `ev_err[7]` sets bit 15 (illegal access).
- R3: A sticky flag stays set until software clears it.
- R4: In a write to a status word, a data bit of 0 clears the matching sticky flag and a data bit of 1 leaves it unchanged. A write never sets a flag.
- R5: If an event arrives in the same cycle as a write that clears its flag, the flag is set afterwards.
- R6: Word 2 bit 8 is set on a rising edge of `buf_rd_full`, and bit 9 on a rising edge of `buf_wr_empty`. If a flag is cleared while its level stays high, the flag stays clear. The next rising edge sets it again.
- R7: `card_det_raw` passes through `SYNC_STAGES` flip-flops, and the result is shown live in word 1 bit 5. A rising edge of the synchronized value sets word 1 bit 4 (inserted). A falling edge sets word 1 bit 3 (removed).
- R8: Word 2 bit 14 shows `lvl_cmd_busy` and bit 7 shows `lvl_dat0`, both live. Writes have no effect on these bits or on word 1 bit 5.
- R9: The mask words are at 0x040 (for word 1) and 0x044 (for word 2). They are read/write over all 32 bits. A mask bit of 1 keeps its flag away from `irq`. `irq` is the OR of all unmasked sticky flags in both words.
- R10: A read request gives `rd_valid` high and `rd_data` valid in the next cycle. An unmapped offset reads 0, and a write to an unmapped offset has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_en | input | 1 | Read request |
| wr_en | input | 1 | Write request |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, one cycle after `rd_en` |
| rd_valid | output | 1 | `rd_data` holds a fresh read result |
| ev_rsp_done | input | 1 | Pulse: command response complete |
| ev_xfer_done | input | 1 | Pulse: data transfer complete |
| ev_err | input | 8 | Pulses: error events, mapped as in R2 |
| buf_rd_full | input | 1 | Level: read buffer holds a full block |
| buf_wr_empty | input | 1 | Level: write buffer can take a block |
| lvl_cmd_busy | input | 1 | Level: command line busy |
| lvl_dat0 | input | 1 | Level: DAT0 line state |
| card_det_raw | input | 1 | Asynchronous card-detect pin |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench builds the block with `ADDR_W` = 12 and `SYNC_STAGES` = 2. With 12 address bits every offset is decoded in full. This puts the unmapped offset 0x048 within reach, so the bench can read it and write to it and then show that the mask word next to it is unchanged.

With two synchronizer stages, an insertion or a removal appears in word 1 within a few cycles. The bench can therefore cover both card-detect edges, and the clearing of their flags while the live level is held, in a short run.

The bench also exercises the buffer-level edge rule directly. It clears the read-buffer flag while `buf_rd_full` is still high, then drops the level and raises it again.

// File: rtl/sdh_irq_pkg.sv
`timescale 1ns/1ps
package sdh_irq_pkg;
    localparam int DW = 32;

    // byte offsets of the four registers
    localparam int OFF_STAT1 = 'h038;
    localparam int OFF_STAT2 = 'h03C;
    localparam int OFF_MASK1 = 'h040;
    localparam int OFF_MASK2 = 'h044;

    // word 1 bit positions
    localparam int B1_RSP    = 0;
    localparam int B1_XFER   = 2;
    localparam int B1_REMOVE = 3;
    localparam int B1_INSERT = 4;
    localparam int B1_CD     = 5;

    // word 2 bit positions
    localparam int B2_DAT0 = 7;
    localparam int B2_RBUF = 8;
    localparam int B2_WBUF = 9;
    localparam int B2_BUSY = 14;

    localparam int NUM_ERR = 8;

    // sticky positions of each word
    localparam logic [DW-1:0] STICKY1 = 32'h0000_001D;
    localparam logic [DW-1:0] STICKY2 = 32'h0000_837F;

    // error input index -> word 2 bit position
    function automatic int err_pos(input int idx);
        return (idx < NUM_ERR - 1) ? idx : 15;
    endfunction

    typedef struct packed {
        logic [DW-1:0] flags;
        logic [DW-1:0] mask;
    } word_state_t;

    typedef struct packed {
        logic [DW-1:0] data;
        logic          valid;
    } rd_state_t;
endpackage

// File: rtl/sdh_irq_sync.sv
`timescale 1ns/1ps
module sdh_irq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/sdh_irq_edge.sv
`timescale 1ns/1ps
module sdh_irq_edge #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar gi = 0; gi < N; gi++) begin : g_bit
        assign rise_o[gi] = lvl_i[gi] & ~prev_q[gi];
        assign fall_o[gi] = ~lvl_i[gi] & prev_q[gi];
    end
endmodule

// File: rtl/sdh_irq_word.sv
`timescale 1ns/1ps
module sdh_irq_word
    import sdh_irq_pkg::*;
#(
    parameter logic [DW-1:0] STICKY = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] set_i,
    input  logic          flag_wr_i,
    input  logic          mask_wr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] flags_o,
    output logic [DW-1:0] mask_o,
    output logic          pend_o
);
    word_state_t st_d, st_q;
    logic [DW-1:0] keep;

    always_comb begin
        st_d = st_q;
        keep = flag_wr_i ? wdata_i : '1;
        // new events win over a clearing write in the same cycle
        st_d.flags = ((st_q.flags & keep) | set_i) & STICKY;
        if (mask_wr_i) st_d.mask = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.flags <= '0;
            st_q.mask  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.flags;
    assign mask_o  = st_q.mask;
    assign pend_o  = |(st_q.flags & ~st_q.mask);
endmodule

// File: rtl/sdh_irq_status.sv
`timescale 1ns/1ps
module sdh_irq_status
    import sdh_irq_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rd_data,
    output logic              rd_valid,
    input  logic              ev_rsp_done,
    input  logic              ev_xfer_done,
    input  logic [NUM_ERR-1:0] ev_err,
    input  logic              buf_rd_full,
    input  logic              buf_wr_empty,
    input  logic              lvl_cmd_busy,
    input  logic              lvl_dat0,
    input  logic              card_det_raw,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_STAT1 = ADDR_W'(OFF_STAT1);
    localparam logic [ADDR_W-1:0] A_STAT2 = ADDR_W'(OFF_STAT2);
    localparam logic [ADDR_W-1:0] A_MASK1 = ADDR_W'(OFF_MASK1);
    localparam logic [ADDR_W-1:0] A_MASK2 = ADDR_W'(OFF_MASK2);
    localparam int EDGE_N = 3;

    logic cd_s;
    logic [EDGE_N-1:0] lvl_vec, rise_vec, fall_vec;
    logic [DW-1:0] set1, set2, err_set;
    logic [DW-1:0] w1_flags, w2_flags, w1_mask, w2_mask;
    logic [DW-1:0] w1_view, w2_view;
    logic w1_pend, w2_pend;
    logic sel_s1, sel_s2, sel_m1, sel_m2;
    rd_state_t rd_d, rd_q;

    sdh_irq_sync #(.STAGES(SYNC_STAGES)) u_cd_sync (
        .clk(clk), .rst_n(rst_n), .din(card_det_raw), .dout(cd_s)
    );

    assign lvl_vec = {cd_s, buf_wr_empty, buf_rd_full};

    sdh_irq_edge #(.N(EDGE_N)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl_i(lvl_vec),
        .rise_o(rise_vec), .fall_o(fall_vec)
    );

    always_comb begin
        err_set = '0;
        for (int i = 0; i < NUM_ERR; i++) err_set[err_pos(i)] = ev_err[i];
    end

    always_comb begin
        set1 = '0;
        set1[B1_RSP]    = ev_rsp_done;
        set1[B1_XFER]   = ev_xfer_done;
        set1[B1_INSERT] = rise_vec[2];
        set1[B1_REMOVE] = fall_vec[2];
        set2 = err_set;
        set2[B2_RBUF] = rise_vec[0];
        set2[B2_WBUF] = rise_vec[1];
    end

    assign sel_s1 = (addr == A_STAT1);
    assign sel_s2 = (addr == A_STAT2);
    assign sel_m1 = (addr == A_MASK1);
    assign sel_m2 = (addr == A_MASK2);

    sdh_irq_word #(.STICKY(STICKY1)) u_w1 (
        .clk(clk), .rst_n(rst_n), .set_i(set1),
        .flag_wr_i(wr_en & sel_s1), .mask_wr_i(wr_en & sel_m1),
        .wdata_i(wdata), .flags_o(w1_flags), .mask_o(w1_mask), .pend_o(w1_pend)
    );

    sdh_irq_word #(.STICKY(STICKY2)) u_w2 (
        .clk(clk), .rst_n(rst_n), .set_i(set2),
        .flag_wr_i(wr_en & sel_s2), .mask_wr_i(wr_en & sel_m2),
        .wdata_i(wdata), .flags_o(w2_flags), .mask_o(w2_mask), .pend_o(w2_pend)
    );

    always_comb begin
        w1_view = w1_flags;
        w1_view[B1_CD] = cd_s;
        w2_view = w2_flags;
        w2_view[B2_DAT0] = lvl_dat0;
        w2_view[B2_BUSY] = lvl_cmd_busy;
    end

    always_comb begin
        rd_d = rd_q;
        rd_d.valid = rd_en;
        if (rd_en) begin
            if (sel_s1)      rd_d.data = w1_view;
            else if (sel_s2) rd_d.data = w2_view;
            else if (sel_m1) rd_d.data = w1_mask;
            else if (sel_m2) rd_d.data = w2_mask;
            else             rd_d.data = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data  = rd_q.data;
    assign rd_valid = rd_q.valid;
    assign irq      = w1_pend | w2_pend;
endmodule

// File: rtl/sdh_irq_status_chk.sv
`timescale 1ns/1ps
module sdh_irq_status_chk
    import sdh_irq_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DW-1:0]     wdata,
    input logic              ev_rsp_done,
    input logic [NUM_ERR-1:0] ev_err,
    input logic              buf_rd_full,
    input logic [DW-1:0]     flags1,
    input logic [DW-1:0]     flags2,
    input logic              irq
);
    logic wr1, wr2;
    assign wr1 = wr_en && (addr == ADDR_W'(OFF_STAT1));
    assign wr2 = wr_en && (addr == ADDR_W'(OFF_STAT2));

    p_rsp_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rsp_done |=> flags1[0]);

    p_ila_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_err[7] |=> flags2[15]);

    p_sticky_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (flags1[2] && !wr1) |=> flags1[2]);

    p_zero_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr1 && !wdata[0] && !ev_rsp_done) |=> !flags1[0]);

    p_write_no_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr2 && !ev_err[3] && !flags2[3]) |=> !flags2[3]);

    p_event_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr1 && !wdata[0] && ev_rsp_done) |=> flags1[0]);

    p_level_no_retrigger_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr2 && !wdata[8] && buf_rd_full && $past(buf_rd_full)) |=> !flags2[8]);

    p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((flags1 | flags2) != '0));
endmodule

bind sdh_irq_status sdh_irq_status_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .ev_rsp_done(ev_rsp_done), .ev_err(ev_err), .buf_rd_full(buf_rd_full),
    .flags1(w1_flags), .flags2(w2_flags), .irq(irq)
);

// File: tb/sdh_irq_status_tb.sv
`timescale 1ns/1ps
module sdh_irq_status_tb_top;
    localparam int AW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_en = 0, wr_en = 0;
    logic [AW-1:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rd_data;
    logic rd_valid;
    logic ev_rsp_done = 0, ev_xfer_done = 0;
    logic [7:0] ev_err = '0;
    logic buf_rd_full = 0, buf_wr_empty = 0;
    logic lvl_cmd_busy = 0, lvl_dat0 = 0, card_det_raw = 0;
    logic irq;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    sdh_irq_status #(.ADDR_W(AW), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rd_data(rd_data), .rd_valid(rd_valid),
        .ev_rsp_done(ev_rsp_done), .ev_xfer_done(ev_xfer_done), .ev_err(ev_err),
        .buf_rd_full(buf_rd_full), .buf_wr_empty(buf_wr_empty),
        .lvl_cmd_busy(lvl_cmd_busy), .lvl_dat0(lvl_dat0),
        .card_det_raw(card_det_raw), .irq(irq)
    );

    // monitor: pops an expected item for every read result
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            tests++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R10 unexpected read result actual=%h expected=none", rd_data);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (rd_data !== e) begin
                    fails++;
                    $display("FAIL %s actual=%h expected=%h", t, rd_data, e);
                end
            end
        end
    end

    task automatic rd(input int a, input logic [31:0] e, input string t);
        rd_en = 1; addr = AW'(a);
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        rd_en = 0;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        wr_en = 1; addr = AW'(a); wdata = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_irq(input logic e, input string t);
        tests++;
        if (irq !== e) begin
            fails++;
            $display("FAIL %s irq actual=%b expected=%b", t, irq, e);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1;
        idle(1);
        // R1 reset state
        chk_irq(1'b0, "R1 reset irq");
        rd('h038, 32'h0, "R1 word1 after reset");
        rd('h03C, 32'h0, "R1 word2 after reset");
        rd('h040, 32'hFFFF_FFFF, "R1 mask1 after reset");
        rd('h044, 32'hFFFF_FFFF, "R1 mask2 after reset");

        // R2 events, R9 masked
        ev_rsp_done = 1; ev_xfer_done = 1;
        idle(1);
        ev_rsp_done = 0; ev_xfer_done = 0;
        chk_irq(1'b0, "R9 masked flags give no irq");
        rd('h038, 32'h5, "R2 response and transfer flags");
        idle(3);
        rd('h038, 32'h5, "R3 flags held");

        // R4 clear by zero, keep by one
        wr('h038, 32'hFFFF_FFFE);
        rd('h038, 32'h4, "R4 zero clears bit0 only");
        wr('h03C, 32'hFFFF_FFFF);
        rd('h03C, 32'h0, "R4 write of ones sets nothing");

        // R5 event beats clear
        ev_rsp_done = 1;
        wr('h038, 32'h0);
        ev_rsp_done = 0;
        rd('h038, 32'h1, "R5 event wins over clearing write");
        wr('h038, 32'h0);

        // R2 error map
        ev_err = 8'hFF; idle(1); ev_err = 8'h00;
        rd('h03C, 32'h0000_807F, "R2 all error flags");
        wr('h03C, 32'h0);
        ev_err = 8'h81; idle(1); ev_err = 8'h00;
        rd('h03C, 32'h0000_8001, "R2 illegal access and index error");
        wr('h03C, 32'h0);

        // R6 buffer edges
        buf_rd_full = 1;
        idle(1);
        rd('h03C, 32'h100, "R6 read buffer rising edge");
        wr('h03C, 32'h0);
        idle(2);
        rd('h03C, 32'h0, "R6 held level does not set again");
        buf_rd_full = 0; idle(1);
        buf_rd_full = 1; idle(1);
        rd('h03C, 32'h100, "R6 second rising edge");
        buf_wr_empty = 1; idle(1);
        rd('h03C, 32'h300, "R6 write buffer rising edge");
        wr('h03C, 32'h0);
        buf_rd_full = 0; buf_wr_empty = 0;
        idle(1);
        rd('h03C, 32'h0, "R6 flags clear after levels drop");

        // R7 card detect
        card_det_raw = 1;
        idle(5);
        rd('h038, 32'h30, "R7 insert and live detect");
        wr('h038, 32'h0);
        rd('h038, 32'h20, "R7 live detect survives clear");
        card_det_raw = 0;
        idle(5);
        rd('h038, 32'h08, "R7 removal flag");
        wr('h038, 32'h0);
        rd('h038, 32'h0, "R7 removal cleared");

        // R8 live levels
        lvl_cmd_busy = 1; lvl_dat0 = 1;
        idle(1);
        rd('h03C, 32'h4080, "R8 busy and dat0 shown");
        wr('h03C, 32'h0);
        rd('h03C, 32'h4080, "R8 write does not touch live bits");
        lvl_cmd_busy = 0; lvl_dat0 = 0;
        idle(1);
        rd('h03C, 32'h0, "R8 live bits follow inputs");

        // R9 masking
        wr('h040, 32'hFFFF_FFFE);
        chk_irq(1'b0, "R9 unmasked but no flag");
        ev_rsp_done = 1; idle(1); ev_rsp_done = 0;
        chk_irq(1'b1, "R9 unmasked word1 flag raises irq");
        wr('h038, 32'h0);
        chk_irq(1'b0, "R9 irq drops after clear");
        rd('h040, 32'hFFFF_FFFE, "R9 mask1 readback");
        wr('h044, 32'hFFFF_FFF7);
        ev_err = 8'h08; idle(1); ev_err = 8'h00;
        chk_irq(1'b1, "R9 unmasked word2 flag raises irq");
        wr('h044, 32'hFFFF_FFFF);
        chk_irq(1'b0, "R9 masking again hides flag");
        rd('h03C, 32'h8, "R9 flag kept while masked");
        rd('h044, 32'hFFFF_FFFF, "R9 mask2 readback");

        // R10 unmapped offset
        wr('h048, 32'h0);
        rd('h040, 32'hFFFF_FFFE, "R10 unmapped write leaves mask1");
        rd('h048, 32'h0, "R10 unmapped reads zero");
        idle(3);

        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R10 missing read results actual=%0d expected=0", exp_q.size());
        end
        done = 1;
        summary();
        $finish;
    end
endmodule